// File: doc/BRIEF.md
# Parallel Flash Command Sequencer with Erase Status Polling

This block is the command front end of a byte-wide parallel NOR flash. It watches a write strobe, a 19-bit address bus and an 8-bit data bus. It recognises command sequences that begin with two coded unlock writes. The main sequence is a six-write chip erase. When the erase starts, an internal engine first clears every location to 00h and then sets every location to FFh. It handles one location per clock and can repeat the FFh pass up to a parameterised number of attempts.

While the engine runs, reads return a status byte instead of array data, so the host polls for completion without a ready pin. A second unlock sequence enters a signature mode. In that mode a read at a qualifying address returns the protection flag of the 1-of-8 block selected by the three top address bits.

The storage is a small register file. Each block keeps `2**WPB_W` bytes, indexed by the top three and the low `WPB_W` address bits, and has a fixed protect flag. A test input forces every verify to fail, so the failure path can be exercised.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset the block is in array mode. A read of location i returns `((i*8) mod 256) XOR A5h`, where i = {addr[18:16], addr[1:0]}.
- R2: The unlock pair is AAh at address 5555h, then 55h at 2AAAh, compared on addr[14:0] only. The chip erase is: unlock pair, 80h at 5555h, unlock pair, 10h at 5555h.
- R3: Any write that breaks a sequence ends it and returns reads to array data. This covers a wrong coded write, a wrong address, a third byte other than 80h/90h, and a sixth byte other than 10h. An aborted erase leaves the array unchanged.
- R4: The erase changes one location per clock. Locations 0..N-1 are written to 00h, then to FFh. Without a forced failure, completion comes exactly 2*N clocks after the clock that takes the sixth write, with every location at FFh.
- R5: From the clock after the sixth write, reads return status {bit7, bit6, bit5, 5'b0}. While busy, bit7=0 and bit5=0. While busy or finished, writes other than F0h have no effect.
- R6: Status bit6 starts at 0 when the erase starts and inverts after each status read taken while busy. Once the erase has finished, bit6 no longer changes.
- R7: A successful erase reads bit7=1, bit5=0. With the fail input held high, the engine makes MAX_TRIES FFh passes. It finishes N*(1+MAX_TRIES) clocks after the sixth write and then reads bit7=0, bit5=1.
- R8: A write of F0h at any address, in any state, returns reads to array data. During an erase it stops the engine at once: locations already processed keep their new value and the rest keep their old value.
- R9: The unlock pair followed by 90h at 5555h enters signature mode. There, a read with addr[0]=0, addr[1]=1 and addr[6]=0 returns 01h if protect bit addr[18:16] of PROT_MASK is set and 00h otherwise. Other addresses read 00h.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Write strobe, one write per clock it is high |
| rd_i | input | 1 | Read strobe, marks a status read for the toggle bit |
| addr_i | input | 19 | Byte address |
| wdata_i | input | 8 | Write data |
| force_fail_i | input | 1 | Test input: every erase verify fails while high |
| rdata_o | output | 8 | Read data, combinational from mode, address and state |

## Verification
The assertions check the following on every cycle:
- the status encoding while busy;
- the bit6 inversion between back-to-back busy reads, and its freeze once the erase has finished;
- that F0h always lands in array mode, and that other writes cannot take the block out of busy;
- that signature reads never set bits above bit 0.

The bench scenarios show the rest:
- which write sequences are accepted or aborted, including address matching on the low 15 bits only;
- the exact erase duration with and without forced failure;
- the array contents after a completed or abandoned erase;
- the per-block protection values.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;
  typedef enum logic [1:0] {MODE_ARRAY, MODE_SIG, MODE_BUSY, MODE_DONE} rd_mode_e;
  typedef enum logic [2:0] {CS_IDLE, CS_UNL1, CS_UNL2, CS_ESET, CS_EUNL1, CS_EUNL2} cmd_st_e;

  localparam logic [14:0] UNL_ADDR_A = 15'h5555;
  localparam logic [14:0] UNL_ADDR_B = 15'h2AAA;
  localparam logic [7:0]  KEY_A      = 8'hAA;
  localparam logic [7:0]  KEY_B      = 8'h55;
  localparam logic [7:0]  OP_ESETUP  = 8'h80;
  localparam logic [7:0]  OP_ECONF   = 8'h10;
  localparam logic [7:0]  OP_SIGNAT  = 8'h90;
  localparam logic [7:0]  OP_RESET   = 8'hF0;

  function automatic logic [7:0] init_byte(input int unsigned i);
    logic [31:0] sh;
    sh = i << 3;
    return sh[7:0] ^ 8'hA5;
  endfunction
endpackage

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
  import flash_seq_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_i,
  input  logic [14:0] addr_i,
  input  logic [7:0]  data_i,
  input  logic        lock_i,
  output logic        reset_cmd_o,
  output logic        abort_o,
  output logic        sig_o,
  output logic        erase_go_o
);
  cmd_st_e st_q, st_d;
  logic    at_a, at_b;

  assign at_a = (addr_i == UNL_ADDR_A);
  assign at_b = (addr_i == UNL_ADDR_B);

  always_comb begin
    st_d        = st_q;
    reset_cmd_o = 1'b0;
    abort_o     = 1'b0;
    sig_o       = 1'b0;
    erase_go_o  = 1'b0;
    if (wr_i) begin
      if (data_i == OP_RESET) begin
        reset_cmd_o = 1'b1;
        st_d        = CS_IDLE;
      end else if (lock_i) begin
        st_d = CS_IDLE;  // busy: everything but reset is dropped
      end else begin
        st_d    = CS_IDLE;
        abort_o = 1'b1;
        case (st_q)
          CS_IDLE:  if (at_a && data_i == KEY_A) begin st_d = CS_UNL1; abort_o = 1'b0; end
          CS_UNL1:  if (at_b && data_i == KEY_B) begin st_d = CS_UNL2; abort_o = 1'b0; end
          CS_UNL2: begin
            if (at_a && data_i == OP_ESETUP) begin
              st_d    = CS_ESET;
              abort_o = 1'b0;
            end else if (at_a && data_i == OP_SIGNAT) begin
              sig_o   = 1'b1;
              abort_o = 1'b0;
            end
          end
          CS_ESET:  if (at_a && data_i == KEY_A) begin st_d = CS_EUNL1; abort_o = 1'b0; end
          CS_EUNL1: if (at_b && data_i == KEY_B) begin st_d = CS_EUNL2; abort_o = 1'b0; end
          CS_EUNL2: if (at_a && data_i == OP_ECONF) begin erase_go_o = 1'b1; abort_o = 1'b0; end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= CS_IDLE;
    else         st_q <= st_d;
  end
endmodule

// File: rtl/flash_erase_engine.sv
module flash_erase_engine #(
  parameter int IDX_W     = 5,
  parameter int MAX_TRIES = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             force_fail_i,
  output logic             wr_en_o,
  output logic [IDX_W-1:0] wr_idx_o,
  output logic [7:0]       wr_data_o,
  output logic             done_o,
  output logic             fail_o
);
  localparam int N_LOC = 1 << IDX_W;
  localparam int TRY_W = $clog2(MAX_TRIES + 1);

  logic             run_q, ers_ph_q, fail_q;
  logic [IDX_W-1:0] idx_q;
  logic [TRY_W-1:0] tries_q;
  logic             last, pass_end, no_more;

  assign last      = (idx_q == IDX_W'(N_LOC - 1));
  assign wr_en_o   = run_q & ~stop_i;
  assign wr_idx_o  = idx_q;
  assign wr_data_o = ers_ph_q ? 8'hFF : 8'h00;
  assign pass_end  = wr_en_o & ers_ph_q & last;
  assign no_more   = (tries_q == TRY_W'(MAX_TRIES - 1));
  assign done_o    = pass_end & (~force_fail_i | no_more);
  assign fail_o    = fail_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q    <= 1'b0;
      ers_ph_q <= 1'b0;
      fail_q   <= 1'b0;
      idx_q    <= '0;
      tries_q  <= '0;
    end else if (start_i) begin
      run_q    <= 1'b1;
      ers_ph_q <= 1'b0;
      fail_q   <= 1'b0;
      idx_q    <= '0;
      tries_q  <= '0;
    end else if (stop_i) begin
      run_q <= 1'b0;
    end else if (run_q) begin
      idx_q <= last ? '0 : idx_q + 1'b1;
      if (last && !ers_ph_q) ers_ph_q <= 1'b1;
      if (pass_end) begin
        if (done_o) begin
          run_q  <= 1'b0;
          fail_q <= force_fail_i;
        end else begin
          tries_q <= tries_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/flash_store.sv
module flash_store
  import flash_seq_pkg::*;
#(
  parameter int                     IDX_W     = 5,
  parameter int                     BLK_W     = 3,
  parameter logic [(1<<BLK_W)-1:0] PROT_MASK = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [7:0]       wr_data_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  input  logic [BLK_W-1:0] rd_blk_i,
  output logic [7:0]       rd_data_o,
  output logic             prot_o
);
  localparam int N_LOC = 1 << IDX_W;

  logic [7:0] mem_q [N_LOC];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N_LOC; i++) mem_q[i] <= init_byte(i);
    end else if (wr_en_i) begin
      mem_q[wr_idx_i] <= wr_data_i;
    end
  end

  assign rd_data_o = mem_q[rd_idx_i];
  assign prot_o    = PROT_MASK[rd_blk_i];
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_seq_pkg::*;
#(
  parameter int         WPB_W     = 2,
  parameter int         MAX_TRIES = 4,
  parameter logic [7:0] PROT_MASK = 8'h25
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_i,
  input  logic        rd_i,
  input  logic [18:0] addr_i,
  input  logic [7:0]  wdata_i,
  input  logic        force_fail_i,
  output logic [7:0]  rdata_o
);
  localparam int BLK_W = 3;
  localparam int IDX_W = BLK_W + WPB_W;

  rd_mode_e         mode_q;
  logic             tgl_q;
  logic             lock, rst_cmd, abort, sig_go, erase_go;
  logic             eng_we, eng_done, eng_fail;
  logic [IDX_W-1:0] eng_idx, rd_idx;
  logic [7:0]       eng_data, arr_data;
  logic             blk_prot, sig_hit;
  logic             unused_addr;

  assign unused_addr = addr_i[15];
  assign lock        = (mode_q == MODE_BUSY) || (mode_q == MODE_DONE);
  assign rd_idx      = {addr_i[18:16], addr_i[WPB_W-1:0]};
  assign sig_hit     = ~addr_i[0] & addr_i[1] & ~addr_i[6];

  flash_cmd_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_i        (wr_i),
    .addr_i      (addr_i[14:0]),
    .data_i      (wdata_i),
    .lock_i      (lock),
    .reset_cmd_o (rst_cmd),
    .abort_o     (abort),
    .sig_o       (sig_go),
    .erase_go_o  (erase_go)
  );

  flash_erase_engine #(.IDX_W(IDX_W), .MAX_TRIES(MAX_TRIES)) u_eng (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (erase_go),
    .stop_i       (rst_cmd),
    .force_fail_i (force_fail_i),
    .wr_en_o      (eng_we),
    .wr_idx_o     (eng_idx),
    .wr_data_o    (eng_data),
    .done_o       (eng_done),
    .fail_o       (eng_fail)
  );

  flash_store #(.IDX_W(IDX_W), .BLK_W(BLK_W), .PROT_MASK(PROT_MASK)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (eng_we),
    .wr_idx_i  (eng_idx),
    .wr_data_i (eng_data),
    .rd_idx_i  (rd_idx),
    .rd_blk_i  (addr_i[18:16]),
    .rd_data_o (arr_data),
    .prot_o    (blk_prot)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_ARRAY;
      tgl_q  <= 1'b0;
    end else begin
      if (rst_cmd)                            mode_q <= MODE_ARRAY;
      else if (erase_go)                      mode_q <= MODE_BUSY;
      else if (sig_go)                        mode_q <= MODE_SIG;
      else if (abort)                         mode_q <= MODE_ARRAY;
      else if (mode_q == MODE_BUSY && eng_done) mode_q <= MODE_DONE;

      if (erase_go)                          tgl_q <= 1'b0;
      else if (rd_i && mode_q == MODE_BUSY)  tgl_q <= ~tgl_q;
    end
  end

  always_comb begin
    case (mode_q)
      MODE_ARRAY: rdata_o = arr_data;
      MODE_SIG:   rdata_o = {7'd0, sig_hit & blk_prot};
      MODE_BUSY:  rdata_o = {1'b0, tgl_q, 6'd0};
      default:    rdata_o = {~eng_fail, tgl_q, eng_fail, 5'd0};
    endcase
  end
endmodule

// File: rtl/flash_cmd_seq_chk.sv
module flash_cmd_seq_chk
  import flash_seq_pkg::*;
(
  input logic        clk_i,
  input logic        rst_ni,
  input logic        wr_i,
  input logic        rd_i,
  input logic [18:0] addr_i,
  input logic [7:0]  wdata_i,
  input logic [7:0]  rdata_o,
  input rd_mode_e    mode_q
);
  p_busy_status_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_q == MODE_BUSY |-> (rdata_o[7] == 1'b0 && rdata_o[5] == 1'b0 && rdata_o[4:0] == 5'd0));

  p_busy_ignores_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_BUSY && wr_i && wdata_i != 8'hF0)
    |=> (mode_q == MODE_BUSY || mode_q == MODE_DONE));

  p_toggle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_BUSY && rd_i && $past(mode_q == MODE_BUSY && rd_i))
    |-> rdata_o[6] != $past(rdata_o[6]));

  p_frozen_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_DONE && $past(mode_q == MODE_DONE)) |-> $stable(rdata_o));

  p_reset_cmd_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && wdata_i == 8'hF0) |=> mode_q == MODE_ARRAY);

  p_sig_byte_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_q == MODE_SIG |-> (rdata_o[7:1] == 7'd0 &&
                            (addr_i[1] && !addr_i[0] && !addr_i[6] || rdata_o[0] == 1'b0)));
endmodule

bind flash_cmd_seq flash_cmd_seq_chk u_chk (.*);

// File: tb/flash_cmd_seq_bench.sv
module flash_cmd_seq_bench;
  localparam int         NL   = 32;
  localparam int         MAXT = 4;
  localparam logic [7:0] PROT = 8'h25;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_i = 1'b0, rd_i = 1'b0, force_fail_i = 1'b0;
  logic [18:0] addr_i = '0;
  logic [7:0]  wdata_i = '0;
  logic [7:0]  rdata_o;

  int    checks = 0, failures = 0;
  string cur_req = "R1";
  bit    live = 1'b0;

  flash_cmd_seq u_flash_cmd_seq (
    .clk_i(clk), .rst_ni(rst_ni), .wr_i(wr_i), .rd_i(rd_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .force_fail_i(force_fail_i), .rdata_o(rdata_o)
  );

  always #10 clk = ~clk;

  // reference model
  int         m_mode;  // 0 array, 1 signature, 2 busy, 3 finished
  int         m_step, m_k, m_dur;
  bit         m_tgl, m_fail;
  logic [7:0] m_mem [NL];

  function automatic logic [7:0] init_val(int i);
    return 8'((i * 8) % 256) ^ 8'hA5;
  endfunction

  function automatic bit seq_ok(int s, logic [18:0] a, logic [7:0] d);
    int lo;
    lo = int'(a[14:0]);
    case (s)
      0, 3:    return lo == 'h5555 && d == 8'hAA;
      1, 4:    return lo == 'h2AAA && d == 8'h55;
      2:       return lo == 'h5555 && (d == 8'h80 || d == 8'h90);
      default: return lo == 'h5555 && d == 8'h10;
    endcase
  endfunction

  function automatic logic [7:0] m_expect(logic [18:0] a);
    int idx;
    idx = int'(a[18:16]) * 4 + int'(a[1:0]);
    case (m_mode)
      0:       return m_mem[idx];
      1:       return (!a[0] && a[1] && !a[6]) ? {7'd0, PROT[a[18:16]]} : 8'h00;
      2:       return {1'b0, m_tgl, 6'd0};
      default: return {~m_fail, m_tgl, m_fail, 5'd0};
    endcase
  endfunction

  task automatic model_reset();
    m_mode = 0; m_step = 0; m_k = 0; m_dur = 0; m_tgl = 0; m_fail = 0;
    for (int i = 0; i < NL; i++) m_mem[i] = init_val(i);
  endtask

  always @(posedge clk) begin
    int pm;
    if (rst_ni) begin
      pm = m_mode;
      if (rd_i && pm == 2) m_tgl = ~m_tgl;
      if (wr_i && wdata_i == 8'hF0) begin
        m_mode = 0; m_step = 0;
      end else begin
        if (pm == 2) begin
          m_k++;
          if (m_k <= NL) m_mem[m_k - 1] = 8'h00;
          else           m_mem[(m_k - NL - 1) % NL] = 8'hFF;
          if (m_k == m_dur) m_mode = 3;
        end
        if (wr_i && pm < 2) begin
          if (seq_ok(m_step, addr_i, wdata_i)) begin
            if (m_step == 2 && wdata_i == 8'h90) begin
              m_mode = 1; m_step = 0;
            end else if (m_step == 5) begin
              m_mode = 2; m_step = 0; m_tgl = 0; m_k = 0;
              m_fail = force_fail_i;
              m_dur  = NL + NL * (force_fail_i ? MAXT : 1);
            end else begin
              m_step++;
            end
          end else begin
            m_step = 0; m_mode = 0;
          end
        end
      end
    end
  end

  // every-cycle comparison, away from the active edge
  always @(negedge clk) begin
    #2;
    if (live) begin
      logic [7:0] e;
      e = m_expect(addr_i);
      checks++;
      if (rdata_o !== e) begin
        failures++;
        $display("FAIL %s model compare addr=%h actual=%h expected=%h", cur_req, addr_i, rdata_o, e);
      end
    end
  end

  task automatic xchk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(bit w, bit r, logic [18:0] a, logic [7:0] d);
    wr_i = w; rd_i = r; addr_i = a; wdata_i = d;
    @(negedge clk);
  endtask

  task automatic wr(logic [18:0] a, logic [7:0] d);
    step(1'b1, 1'b0, a, d);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 19'h0, 8'h00);
  endtask

  task automatic rdchk(string req, logic [18:0] a, logic [7:0] exp);
    wr_i = 1'b0; rd_i = 1'b1; addr_i = a; wdata_i = 8'h00;
    #3;
    xchk(req, rdata_o, exp);
    @(negedge clk);
  endtask

  task automatic unlock();
    wr(19'h05555, 8'hAA);
    wr(19'h02AAA, 8'h55);
  endtask

  task automatic erase_seq();
    // upper address bits set on purpose: only addr[14:0] is compared (R2)
    wr(19'h7D555, 8'hAA);
    wr(19'h3AAAA, 8'h55);
    wr(19'h05555, 8'h80);
    wr(19'h45555, 8'hAA);
    wr(19'h02AAA, 8'h55);
    wr(19'h05555, 8'h10);
  endtask

  initial begin
    int wd;
    wd = 0;
    while (wd < 20000) begin
      @(posedge clk);
      wd++;
    end
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    live = 1'b1;

    // R1 reset state
    cur_req = "R1";
    rdchk("R1", 19'h00000, 8'hA5);
    rdchk("R1", 19'h50003, 8'h1D);
    rdchk("R1", 19'h70001, init_val(29));

    // R9 signature mode and protect bits
    cur_req = "R9";
    unlock();
    wr(19'h05555, 8'h90);
    rdchk("R9", 19'h00002, 8'h01);
    rdchk("R9", 19'h10002, 8'h00);
    rdchk("R9", 19'h20002, 8'h01);
    rdchk("R9", 19'h50002, 8'h01);
    rdchk("R9", 19'h00003, 8'h00);
    rdchk("R9", 19'h20042, 8'h00);

    // R8 reset command leaves signature mode
    cur_req = "R8";
    wr(19'h12345, 8'hF0);
    rdchk("R8", 19'h00002, init_val(2));

    // R3 aborts
    cur_req = "R3";
    unlock();
    wr(19'h05555, 8'h90);
    wr(19'h05555, 8'hAA);
    rdchk("R3", 19'h20002, 8'h01);          // correct first write keeps signature mode
    wr(19'h00000, 8'h55);                   // wrong address
    rdchk("R3", 19'h00002, init_val(2));
    unlock();
    wr(19'h05555, 8'h80);
    wr(19'h05555, 8'hAA);
    wr(19'h02AAA, 8'h54);                   // wrong coded byte
    rdchk("R3", 19'h00001, init_val(1));
    unlock();
    wr(19'h05555, 8'h80);
    unlock();
    wr(19'h05555, 8'h30);                   // wrong confirm
    rdchk("R3", 19'h70003, init_val(31));
    unlock();
    wr(19'h05555, 8'h20);                   // wrong third byte
    rdchk("R3", 19'h30000, init_val(12));

    // R2 R4 R5 R6 R7 successful erase
    cur_req = "R4";
    force_fail_i = 1'b0;
    erase_seq();
    rdchk("R5", 19'h00000, 8'h00);
    rdchk("R6", 19'h00000, 8'h40);
    rdchk("R6", 19'h00000, 8'h00);
    wr(19'h05555, 8'hAA);                   // ignored while busy
    rdchk("R5", 19'h00000, 8'h40);
    idle(58);
    rdchk("R4", 19'h00000, 8'h00);          // 63 clocks in: still busy
    rdchk("R7", 19'h00000, 8'hC0);          // 64 clocks: finished
    wr(19'h05555, 8'h80);                   // ignored once finished
    rdchk("R6", 19'h00000, 8'hC0);
    wr(19'h00000, 8'hF0);
    rdchk("R2", 19'h00000, 8'hFF);
    rdchk("R4", 19'h50003, 8'hFF);
    rdchk("R4", 19'h70003, 8'hFF);

    // R7 forced failure
    cur_req = "R7";
    force_fail_i = 1'b1;
    erase_seq();
    idle(159);
    rdchk("R7", 19'h00000, 8'h00);          // 159 clocks in: busy
    rdchk("R7", 19'h00000, 8'h60);          // 160 clocks: failed
    rdchk("R7", 19'h00000, 8'h60);
    wr(19'h00000, 8'hF0);
    force_fail_i = 1'b0;

    // R8 reset during erase
    cur_req = "R8";
    erase_seq();
    idle(10);
    wr(19'h6ABCD, 8'hF0);
    rdchk("R8", 19'h00001, 8'h00);          // processed location
    rdchk("R8", 19'h70003, 8'hFF);          // untouched location
    rdchk("R8", 19'h70003, 8'hFF);
    idle(5);

    live = 1'b0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule